// File: doc/BRIEF.md
# Per-Peripheral Clock Ratio Selector

This block turns one core clock into a bank of clock-enable strobes, one per peripheral, each running at a ratio picked by a 2-bit code. The codes sit sixteen to a 32-bit register, with two registers covering 32 peripherals. A single-cycle write port replaces a whole register at once, and a combinational read port returns the current codes of the register chosen by the read select.

Each strobe is one core cycle wide and repeats once per selected period. Code 01 keeps the strobe high every cycle. The mapping from code to ratio is not monotonic, and two kinds of peripheral bend it. The peripherals marked as controller-area-network channels run at one sixth of the core clock for code 11 instead of one eighth. The timekeeping peripheral refuses code 01. A write of that code leaves its previous code in place, and the read port shows the old value.

A new code never cuts a period short. A channel takes up its new ratio only when its current period ends, so no strobe is shortened or doubled.

Top module: `pclk_ratio_sel`

## Requirements
- R1: After reset every field holds code 00: both registers read back 0 and every strobe repeats every 4 core cycles.
- R2: A write with `wr_en` high replaces all sixteen fields of the register chosen by `wr_sel`. Peripheral i uses register i/16, bits 2*(i%16)+1 to 2*(i%16). `rd_data` shows the register chosen by `rd_sel` in the same cycle, and fields change only on a write.
- R3: Code 00 makes the strobe repeat every 4 cycles.
- R4: Code 01 holds the strobe high on every cycle.
- R5: Code 10 makes the strobe repeat every 2 cycles.
- R6: Code 11 makes the strobe repeat every 8 cycles for an ordinary peripheral.
- R7: For peripherals set in `CAN_MASK` (default 13, 14 and 15), code 11 makes the strobe repeat every 6 cycles. Their other codes follow R3 to R5.
- R8: For peripheral `RTC_IDX` (default 22, register 1 bits 13:12), a write of code 01 leaves the field at its previous value. Any other code is stored.
- R9: A new code takes effect at the end of the channel's current period. The period that is running completes at its old length, and the next one uses the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_sel | input | 1 | Register chosen for the write |
| wr_data | input | 32 | Sixteen 2-bit codes to store |
| rd_sel | input | 1 | Register chosen for readback |
| rd_data | output | 32 | Codes currently held in the chosen register |
| clk_en | output | 32 | One enable strobe per peripheral |

## Verification
A write lands at the clock edge that samples `wr_en`, and the new code shows on `rd_data` from the next cycle. The strobe does not change its spacing until the first strobe after that edge, because the channel loads its ratio only at a period boundary. For this reason the bench never measures the first gap after a write. It waits for a strobe, then counts the cycles to the next one, sampling on falling edges. For R9 it writes in the same cycle as a strobe, so the old period must still be counted in full before the new one starts.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

  localparam int CODE_W = 2;
  localparam int CNT_W  = 3;

  localparam logic [CODE_W-1:0] CODE_DIV4 = 2'b00;
  localparam logic [CODE_W-1:0] CODE_DIV1 = 2'b01;
  localparam logic [CODE_W-1:0] CODE_DIV2 = 2'b10;
  localparam logic [CODE_W-1:0] CODE_SLOW = 2'b11;

  // Returns the terminal count (period minus one) for a field code.
  function automatic logic [CNT_W-1:0] code_to_last(input logic [CODE_W-1:0] code,
                                                    input logic            can_rule);
    logic [CNT_W-1:0] last;
    unique case (code)
      CODE_DIV4: last = 3'd3;
      CODE_DIV1: last = 3'd0;
      CODE_DIV2: last = 3'd1;
      default:   last = can_rule ? 3'd5 : 3'd7;
    endcase
    return last;
  endfunction

endpackage

// File: rtl/pclk_sel_regs.sv
module pclk_sel_regs #(
  parameter int NUM_REGS       = 2,
  parameter int FIELDS_PER_REG = 16,
  parameter int RTC_IDX        = 22,
  localparam int NUM_CH        = NUM_REGS * FIELDS_PER_REG,
  localparam int REG_W         = FIELDS_PER_REG * pclk_pkg::CODE_W,
  localparam int SEL_W         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [REG_W-1:0]               wr_data,
  input  logic [SEL_W-1:0]               rd_sel,
  output logic [REG_W-1:0]               rd_data,
  output logic [NUM_CH*pclk_pkg::CODE_W-1:0] sel_q
);
  import pclk_pkg::*;

  logic [NUM_CH*CODE_W-1:0] sel_d;

  // Next-state: a write replaces every field of the chosen register,
  // except that the timekeeping field refuses the continuous code.
  always_comb begin
    sel_d = sel_q;
    for (int i = 0; i < NUM_CH; i++) begin
      logic [CODE_W-1:0] wcode;
      wcode = wr_data[CODE_W*(i % FIELDS_PER_REG) +: CODE_W];
      if (wr_en && (int'(wr_sel) == (i / FIELDS_PER_REG))) begin
        if (!((i == RTC_IDX) && (wcode == CODE_DIV1))) begin
          sel_d[CODE_W*i +: CODE_W] = wcode;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (wr_en) begin
      sel_q <= sel_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (int'(rd_sel) == r) begin
        rd_data = sel_q[REG_W*r +: REG_W];
      end
    end
  end

endmodule

// File: rtl/pclk_div_chan.sv
module pclk_div_chan #(
  parameter bit CAN_RULE = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [pclk_pkg::CODE_W-1:0]   code,
  output logic                          en
);
  import pclk_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d;

  assign en = (cnt_q == last_q);

  // The ratio is reloaded only at the period boundary.
  always_comb begin
    if (en) begin
      cnt_d  = '0;
      last_d = code_to_last(code, CAN_RULE);
    end else begin
      cnt_d  = cnt_q + 1'b1;
      last_d = last_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 3'd3;
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/pclk_ratio_sel.sv
module pclk_ratio_sel #(
  parameter int NUM_REGS       = 2,
  parameter int FIELDS_PER_REG = 16,
  parameter int RTC_IDX        = 22,
  parameter logic [NUM_REGS*FIELDS_PER_REG-1:0] CAN_MASK = 32'h0000_E000,
  localparam int NUM_CH        = NUM_REGS * FIELDS_PER_REG,
  localparam int REG_W         = FIELDS_PER_REG * pclk_pkg::CODE_W,
  localparam int SEL_W         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] clk_en
);
  import pclk_pkg::*;

  logic [NUM_CH*CODE_W-1:0] sel_q;

  pclk_sel_regs #(
    .NUM_REGS      (NUM_REGS),
    .FIELDS_PER_REG(FIELDS_PER_REG),
    .RTC_IDX       (RTC_IDX)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .rd_sel (rd_sel),
    .rd_data(rd_data),
    .sel_q  (sel_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pclk_div_chan #(
      .CAN_RULE(CAN_MASK[g])
    ) u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .code (sel_q[CODE_W*g +: CODE_W]),
      .en   (clk_en[g])
    );
  end

endmodule

// File: rtl/pclk_ratio_sel_chk.sv
module pclk_ratio_sel_chk #(
  parameter int NUM_REGS       = 2,
  parameter int FIELDS_PER_REG = 16,
  parameter int RTC_IDX        = 22,
  localparam int NUM_CH        = NUM_REGS * FIELDS_PER_REG,
  localparam int REG_W         = FIELDS_PER_REG * 2,
  localparam int SEL_W         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int RTC_REG       = RTC_IDX / FIELDS_PER_REG,
  localparam int RTC_OFF       = RTC_IDX % FIELDS_PER_REG
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [REG_W-1:0]  wr_data,
  input logic [NUM_CH*2-1:0] sel_q,
  input logic [NUM_CH-1:0] clk_en
);

  a_r2_quiet_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sel_q));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == SEL_W'(0)) && (RTC_IDX != 0)) |=> (sel_q[1:0] == $past(wr_data[1:0])));

  a_r8_rtc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == SEL_W'(RTC_REG)) && (wr_data[2*RTC_OFF +: 2] == 2'b01))
      |=> (sel_q[2*RTC_IDX +: 2] == $past(sel_q[2*RTC_IDX +: 2])));

  a_r8_rtc_take: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == SEL_W'(RTC_REG)) && (wr_data[2*RTC_OFF +: 2] != 2'b01))
      |=> (sel_q[2*RTC_IDX +: 2] == $past(wr_data[2*RTC_OFF +: 2])));

  // Two strobes in a row are only possible when the continuous code was loaded.
  a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en[0] && $past(clk_en[0])) |-> ($past(sel_q[1:0]) == 2'b01));

endmodule

bind pclk_ratio_sel pclk_ratio_sel_chk #(
  .NUM_REGS      (NUM_REGS),
  .FIELDS_PER_REG(FIELDS_PER_REG),
  .RTC_IDX       (RTC_IDX)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_sel (wr_sel),
  .wr_data(wr_data),
  .sel_q  (sel_q),
  .clk_en (clk_en)
);

// File: tb/pclk_ratio_sel_tb.sv
`timescale 1ns/1ps
module pclk_ratio_sel_tb;

  localparam int CH_PLAIN = 0;
  localparam int CH_CAN   = 13;
  localparam int CH_RTC   = 22;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel;
  logic [31:0] wr_data;
  logic        rd_sel;
  logic [31:0] rd_data;
  logic [31:0] clk_en;

  int n_tests;
  int n_fail;
  int cycles;
  logic [31:0] shadow0;
  logic [31:0] shadow1;

  pclk_ratio_sel u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .rd_sel (rd_sel),
    .rd_data(rd_data),
    .clk_en (clk_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int actual, input int expected);
    n_tests++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic set_field(input int idx, input logic [1:0] code);
    if (idx < 16) begin
      shadow0[2*idx +: 2] = code;
      wr_reg(1'b0, shadow0);
    end else begin
      shadow1[2*(idx-16) +: 2] = code;
      wr_reg(1'b1, shadow1);
    end
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] val);
    @(negedge clk);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  task automatic wait_pulse(input int idx);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!clk_en[idx] && guard < 64);
  endtask

  // Gap in cycles from one strobe to the next, starting at a fresh strobe.
  task automatic period_of(input int idx, output int gap);
    wait_pulse(idx);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!clk_en[idx] && gap < 64);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    int gap;
    read_reg(1'b0, v); chk("R1 reg0 reset", int'(v), 0);
    read_reg(1'b1, v); chk("R1 reg1 reset", int'(v), 0);
    period_of(CH_PLAIN, gap); chk("R1 plain reset period", gap, 4);
    period_of(CH_CAN, gap);   chk("R1 can reset period", gap, 4);
    period_of(CH_RTC, gap);   chk("R1 rtc reset period", gap, 4);
  endtask

  task automatic t_plain_codes;
    logic [31:0] v;
    int gap;
    set_field(CH_PLAIN, 2'b01);
    read_reg(1'b0, v); chk("R2 readback after write", int'(v[1:0]), 1);
    period_of(CH_PLAIN, gap); chk("R4 code 01 continuous", gap, 1);
    set_field(CH_PLAIN, 2'b10);
    period_of(CH_PLAIN, gap); chk("R5 code 10 period", gap, 2);
    set_field(CH_PLAIN, 2'b11);
    period_of(CH_PLAIN, gap); chk("R6 code 11 plain period", gap, 8);
    set_field(CH_PLAIN, 2'b00);
    period_of(CH_PLAIN, gap); chk("R3 code 00 period", gap, 4);
  endtask

  task automatic t_can;
    int gap;
    set_field(CH_CAN, 2'b11);
    set_field(CH_PLAIN, 2'b11);
    period_of(CH_CAN, gap);   chk("R7 can code 11 period", gap, 6);
    period_of(CH_PLAIN, gap); chk("R6 plain 11 beside can", gap, 8);
    set_field(CH_CAN, 2'b10);
    period_of(CH_CAN, gap);   chk("R7 can code 10 period", gap, 2);
  endtask

  task automatic t_rtc;
    logic [31:0] v;
    int gap;
    set_field(CH_RTC, 2'b01);
    shadow1[13:12] = 2'b00;
    read_reg(1'b1, v); chk("R8 rtc rejects 01 from reset", int'(v[13:12]), 0);
    period_of(CH_RTC, gap); chk("R8 rtc keeps period 4", gap, 4);
    set_field(CH_RTC, 2'b10);
    read_reg(1'b1, v); chk("R8 rtc takes 10", int'(v[13:12]), 2);
    set_field(CH_RTC, 2'b01);
    shadow1[13:12] = 2'b10;
    read_reg(1'b1, v); chk("R8 rtc rejects 01 after 10", int'(v[13:12]), 2);
    period_of(CH_RTC, gap); chk("R8 rtc period stays 2", gap, 2);
  endtask

  task automatic t_boundary;
    int gap;
    set_field(CH_PLAIN, 2'b11);
    period_of(CH_PLAIN, gap); chk("R6 settled at 8", gap, 8);
    wait_pulse(CH_PLAIN);
    shadow0[1:0] = 2'b01;
    wr_en   = 1'b1;
    wr_sel  = 1'b0;
    wr_data = shadow0;
    gap = 0;
    do begin
      @(negedge clk);
      wr_en = 1'b0;
      gap++;
    end while (!clk_en[CH_PLAIN] && gap < 64);
    chk("R9 old period completes", gap, 8);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!clk_en[CH_PLAIN] && gap < 64);
    chk("R9 new ratio follows", gap, 1);
  endtask

  task automatic t_isolation;
    logic [31:0] v;
    shadow1 = 32'hFFFF_FFFF;
    wr_reg(1'b1, shadow1);
    shadow1[13:12] = 2'b11;
    read_reg(1'b0, v); chk("R2 reg0 untouched by reg1 write", int'(v == shadow0), 1);
    read_reg(1'b1, v); chk("R2 reg1 full write", int'(v == shadow1), 1);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    cycles  = 0;
    shadow0 = '0;
    shadow1 = '0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_sel  = 1'b0;
    wr_data = '0;
    rd_sel  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain_codes();
    t_can();
    t_rtc();
    t_boundary();
    t_isolation();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule